// File: doc/BRIEF.md
# Dual-Width Parallel Host Bus Interface

This block is the slave end of a microprocessor-style parallel bus. It has a register-select line, a read/write line, an enable strobe and an eight-line data bus. The data bus appears as separate input, output and per-line output-enable vectors, so that a pad ring can build the bidirectional pins. Each strobe is one of four access types, chosen by the select and read/write lines:

- writing an instruction byte;
- reading a status byte;
- writing a data byte;
- reading a data byte.

The interface passes each completed instruction or data byte to an execution core over a valid/ready handshake. For status reads it shows the core's busy flag and address counter. It keeps a data register. A data write loads this register. A data read returns the register's contents and then asks the core to fetch the byte at the next address.

The bus width can be changed at run time. The execution core loads the width bit through a one-cycle strobe, and the bit resets to eight-bit transfers. In four-bit mode only the upper four data lines carry information. Every byte takes two strobes, upper nibble first. Nothing is handed to the core until the second strobe has ended, so the busy flag can only rise after the second nibble. The enable line is synchronised to the system clock. Write data and control are captured when the synchronised enable falls.

Top module: `hostbus_if`

## Requirements
- R1: The select/read-write pair decodes as follows: 0/0 is an instruction write, 0/1 is a status read, 1/0 is a data write, and 1/1 is a data read. A completed write is offered on `cmd_byte`, with `cmd_is_data` equal to the select level.
- R2: A status read returns the busy flag on bit 7 and `core_addr` on bits 6..0. The busy flag is the OR of `core_busy`, a pending command handoff and a pending fetch.
- R3: After reset the width bit selects eight-bit transfers. A pulse on `width_wr` loads `width_val` into it, where 1 means eight-bit and 0 means four-bit.
- R4: In four-bit mode each byte takes two strobes on `bus_din[7:4]` / `bus_dout[7:4]`, upper nibble first. This holds for writes and reads alike, and the lower data inputs are ignored.
- R5: In four-bit mode the first nibble of a write causes no handoff. The byte is offered only after the second strobe ends.
- R6: A data write loads the data register, and a data read returns it. After the last strobe of a data read, `fetch_req` rises and stays high until `fetch_valid`. The byte on `fetch_data` at that point replaces the data register.
- R7: The output enables are high only while a read strobe is active. `bus_oe[3:0]` stays low throughout in four-bit mode, so a read there shows 8'hF0 and an eight-bit read shows 8'hFF.
- R8: When the width bit changes, the nibble phase returns to "upper". A half-finished byte is then discarded.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command stays unchanged. A write that completes in that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Enable strobe, asynchronous to clk |
| bus_din | input | 8 | Data bus input side |
| bus_dout | output | 8 | Data bus output side |
| bus_oe | output | 8 | Per-line output enable for the data bus |
| width_wr | input | 1 | One-cycle strobe loading the width bit |
| width_val | input | 1 | New width bit: 1 eight-bit, 0 four-bit |
| core_busy | input | 1 | Execution core busy |
| core_addr | input | 7 | Execution core address counter |
| cmd_valid | output | 1 | Completed byte offered to the core |
| cmd_is_data | output | 1 | 1 data byte, 0 instruction byte |
| cmd_byte | output | 8 | Offered byte |
| cmd_ready | input | 1 | Core accepts the offered byte |
| fetch_req | output | 1 | Request for the byte at the next address |
| fetch_valid | input | 1 | Core supplies the fetched byte |
| fetch_data | input | 8 | Fetched byte |

## Verification
Several properties are checked on every cycle. An offered command stays frozen until it is accepted. A handoff never starts from the middle of a four-bit byte. The lower lanes are never enabled while four-bit mode has been in force for more than a cycle. A width change returns the nibble phase to "upper". A fetch request is cleared by its answer. Only the bench scenarios can show the rest. That covers the values read back, nibble pairing and order, and that a half byte is lost when the width is toggled. It also covers the busy bit rising while a handoff is pending, and a write arriving in that state being dropped.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int unsigned HB_DATA_W = 8;
    localparam int unsigned HB_NIB_W  = HB_DATA_W / 2;
    localparam int unsigned HB_ADDR_W = HB_DATA_W - 1;

    // select / read-write pair
    typedef enum logic [1:0] {
        ACC_INSTR_WR  = 2'b00,
        ACC_STATUS_RD = 2'b01,
        ACC_DATA_WR   = 2'b10,
        ACC_DATA_RD   = 2'b11
    } hb_access_e;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_d,
    output logic [W-1:0] sync_q
);

    logic [STAGES-1:0][W-1:0] chain_q;
    logic [STAGES-1:0][W-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_q = chain_q[STAGES-1];

endmodule

// File: rtl/hb_nibble.sv
module hb_nibble
    import hb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe_end,
    input  logic                 width_wr,
    input  logic                 width_val,
    input  logic [HB_DATA_W-1:0] bus_byte,
    output logic                 width8,
    output logic                 phase_lo,
    output logic                 byte_done,
    output logic [HB_DATA_W-1:0] byte_val
);

    typedef struct packed {
        logic                width8;
        logic                phase_lo;
        logic [HB_NIB_W-1:0] hi;
    } nib_state_t;

    nib_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        byte_done = 1'b0;
        byte_val  = st_q.width8 ? bus_byte
                                : {st_q.hi, bus_byte[HB_DATA_W-1:HB_NIB_W]};
        if (strobe_end) begin
            if (st_q.width8) begin
                byte_done = 1'b1;
            end else if (!st_q.phase_lo) begin
                st_d.hi       = bus_byte[HB_DATA_W-1:HB_NIB_W];
                st_d.phase_lo = 1'b1;
            end else begin
                byte_done     = 1'b1;
                st_d.phase_lo = 1'b0;
            end
        end
        if (width_wr && (width_val != st_q.width8)) begin
            st_d.width8   = width_val;
            st_d.phase_lo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{width8: 1'b1, phase_lo: 1'b0, hi: '0};
        else        st_q <= st_d;
    end

    assign width8   = st_q.width8;
    assign phase_lo = st_q.phase_lo;

    AST_PHASE_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (width_wr && (width_val != st_q.width8)) |=> !phase_lo) // R8
        else $error("nibble phase not rewound on width change");

endmodule

// File: rtl/hb_handoff.sv
module hb_handoff
    import hb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 load_is_data,
    input  logic [HB_DATA_W-1:0] load_byte,
    input  logic                 ready,
    output logic                 valid,
    output logic                 is_data,
    output logic [HB_DATA_W-1:0] out_byte
);

    typedef struct packed {
        logic                 valid;
        logic                 is_data;
        logic [HB_DATA_W-1:0] data;
    } hand_state_t;

    hand_state_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (hs_q.valid && ready) hs_d.valid = 1'b0;
        if (load && !hs_q.valid) begin
            hs_d.valid   = 1'b1;
            hs_d.is_data = load_is_data;
            hs_d.data    = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign valid    = hs_q.valid;
    assign is_data  = hs_q.is_data;
    assign out_byte = hs_q.data;

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(out_byte) && $stable(is_data))) // R9
        else $error("offered command changed before acceptance");

endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_rw,
    input  logic                 bus_en,
    input  logic [HB_DATA_W-1:0] bus_din,
    output logic [HB_DATA_W-1:0] bus_dout,
    output logic [HB_DATA_W-1:0] bus_oe,
    input  logic                 width_wr,
    input  logic                 width_val,
    input  logic                 core_busy,
    input  logic [HB_ADDR_W-1:0] core_addr,
    output logic                 cmd_valid,
    output logic                 cmd_is_data,
    output logic [HB_DATA_W-1:0] cmd_byte,
    input  logic                 cmd_ready,
    output logic                 fetch_req,
    input  logic                 fetch_valid,
    input  logic [HB_DATA_W-1:0] fetch_data
);

    localparam int SYNC_W = HB_DATA_W + 3;

    logic [SYNC_W-1:0]    sync_out;
    logic                 sel_s, rw_s, en_s;
    logic [HB_DATA_W-1:0] din_s;

    hb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d ({bus_sel, bus_rw, bus_en, bus_din}),
        .sync_q  (sync_out)
    );
    assign {sel_s, rw_s, en_s, din_s} = sync_out;

    typedef struct packed {
        logic                 en_prev;
        logic                 oe_hi;
        logic                 oe_lo;
        logic [HB_DATA_W-1:0] dout;
        logic [HB_DATA_W-1:0] snap;
        logic [HB_DATA_W-1:0] dreg;
        logic                 fetch_req;
    } top_state_t;

    top_state_t ts_d, ts_q;

    logic                 en_rise, en_fall;
    logic                 width8, phase_lo, byte_done;
    logic [HB_DATA_W-1:0] byte_val;
    logic                 wr_accept;
    logic                 busy_flag;
    logic [HB_DATA_W-1:0] status_byte, snap_new;
    hb_access_e           acc;

    assign en_rise = en_s & ~ts_q.en_prev;
    assign en_fall = ~en_s & ts_q.en_prev;
    assign acc     = hb_access_e'({sel_s, rw_s});

    hb_nibble u_nibble (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_end (en_fall),
        .width_wr   (width_wr),
        .width_val  (width_val),
        .bus_byte   (din_s),
        .width8     (width8),
        .phase_lo   (phase_lo),
        .byte_done  (byte_done),
        .byte_val   (byte_val)
    );

    assign wr_accept = byte_done && !rw_s && !cmd_valid;

    hb_handoff u_handoff (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (wr_accept),
        .load_is_data (sel_s),
        .load_byte    (byte_val),
        .ready        (cmd_ready),
        .valid        (cmd_valid),
        .is_data      (cmd_is_data),
        .out_byte     (cmd_byte)
    );

    assign busy_flag   = core_busy | cmd_valid | ts_q.fetch_req;
    assign status_byte = {busy_flag, core_addr};
    assign snap_new    = (acc == ACC_DATA_RD) ? ts_q.dreg : status_byte;

    always_comb begin
        ts_d         = ts_q;
        ts_d.en_prev = en_s;
        ts_d.oe_hi   = en_s & rw_s;
        ts_d.oe_lo   = en_s & rw_s & width8;

        // read presentation on the synchronised rising edge
        if (en_rise && rw_s) begin
            if (width8) begin
                ts_d.snap = snap_new;
                ts_d.dout = snap_new;
            end else if (!phase_lo) begin
                ts_d.snap = snap_new;
                ts_d.dout = {snap_new[HB_DATA_W-1:HB_NIB_W], {HB_NIB_W{1'b0}}};
            end else begin
                ts_d.dout = {ts_q.snap[HB_NIB_W-1:0], {HB_NIB_W{1'b0}}};
            end
        end

        // fetched byte from the core
        if (ts_q.fetch_req && fetch_valid) begin
            ts_d.dreg      = fetch_data;
            ts_d.fetch_req = 1'b0;
        end

        // completed accesses
        if (wr_accept && (acc == ACC_DATA_WR)) ts_d.dreg = byte_val;
        if (byte_done && (acc == ACC_DATA_RD)) ts_d.fetch_req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign bus_dout  = ts_q.dout;
    assign bus_oe    = {{HB_NIB_W{ts_q.oe_hi}}, {HB_NIB_W{ts_q.oe_lo}}};
    assign fetch_req = ts_q.fetch_req;

    AST_LOW_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!width8 && $past(!width8)) |-> (bus_oe[HB_NIB_W-1:0] == '0)) // R7
        else $error("lower lanes enabled in four-bit mode");

    AST_WHOLE_BYTE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(width8 || phase_lo)) // R5
        else $error("handoff started from a half byte");

    AST_FETCH_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid && !byte_done) |=> !fetch_req) // R6
        else $error("fetch request survived its answer");

    AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_oe) |-> $past(rw_s)) // R7
        else $error("bus driven outside a read");

endmodule

// File: tb/hostbus_if_bench.sv
module hostbus_if_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout, bus_oe;
    logic       width_wr = 1'b0, width_val = 1'b1;
    logic       core_busy = 1'b0;
    logic [6:0] core_addr = 7'h00;
    logic       cmd_valid, cmd_is_data;
    logic [7:0] cmd_byte;
    logic       cmd_ready = 1'b1;
    logic       fetch_req;
    logic       fetch_valid = 1'b0;
    logic [7:0] fetch_data;

    int n_vec = 0, n_bad = 0;
    int cmd_cnt = 0;
    logic [8:0] last_cmd = '0;
    int fetch_cnt = 0;
    logic cur_w8 = 1'b1;

    always #4 clk = ~clk;

    hostbus_if u_hostbus_if (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rw(bus_rw), .bus_en(bus_en),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .width_wr(width_wr), .width_val(width_val), .core_busy(core_busy),
        .core_addr(core_addr), .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data),
        .cmd_byte(cmd_byte), .cmd_ready(cmd_ready), .fetch_req(fetch_req),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data)
    );

    // execution core model
    assign fetch_data = 8'h90 + 8'(fetch_cnt);
    always @(posedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
                cmd_cnt  <= cmd_cnt + 1;
                last_cmd <= {cmd_is_data, cmd_byte};
            end
            fetch_valid <= fetch_req && !fetch_valid;
            if (fetch_valid && fetch_req) fetch_cnt <= fetch_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic s, input logic r, input logic [7:0] d,
                          output logic [7:0] q, output logic [7:0] oe_seen);
        @(negedge clk);
        bus_sel = s; bus_rw = r; bus_din = d;
        repeat (2) @(negedge clk);
        bus_en = 1'b1;
        repeat (5) @(negedge clk);
        q = bus_dout; oe_seen = bus_oe;
        bus_en = 1'b0;
        repeat (6) @(negedge clk);
        bus_rw = 1'b0;
    endtask

    task automatic width_load(input logic v);
        @(negedge clk);
        width_wr = 1'b1; width_val = v;
        @(negedge clk);
        width_wr = 1'b0;
        cur_w8 = v;
    endtask

    task automatic write_byte(input logic s, input logic [7:0] b, output logic [7:0] oe_seen);
        logic [7:0] q;
        logic [7:0] oe2;
        if (cur_w8) strobe(s, 1'b0, b, q, oe_seen);
        else begin
            strobe(s, 1'b0, {b[7:4], 4'hA}, q, oe_seen);
            strobe(s, 1'b0, {b[3:0], 4'h5}, q, oe2);
            oe_seen = oe_seen | oe2;
        end
    endtask

    task automatic read_byte(input logic s, output logic [7:0] b, output logic [7:0] oe_seen);
        logic [7:0] q1, q2, o1, o2;
        if (cur_w8) strobe(s, 1'b1, 8'h00, b, oe_seen);
        else begin
            strobe(s, 1'b1, 8'h00, q1, o1);
            strobe(s, 1'b1, 8'h00, q2, o2);
            b = {q1[7:4], q2[7:4]};
            oe_seen = o1 & o2;
        end
    endtask

    // {width8, sel, rw, value(byte or addr), expected read}
    localparam logic [18:0] VEC [0:9] = '{
        {1'b1, 1'b0, 1'b0, 8'h38, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h5A, 8'h00},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'h5A},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'h90},
        {1'b1, 1'b0, 1'b1, 8'h23, 8'h23},
        {1'b0, 1'b0, 1'b0, 8'h0C, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'hC3, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'hC3},
        {1'b0, 1'b0, 1'b1, 8'h71, 8'h71},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h92}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd, oe;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset outputs", {6'd0, cmd_valid, fetch_req, bus_oe}, 16'h0000);

        for (int i = 0; i < 10; i++) begin
            logic w8, s, r;
            logic [7:0] val, exp;
            {w8, s, r, val, exp} = VEC[i];
            if (w8 != cur_w8) width_load(w8);
            if (!r) begin
                base = cmd_cnt;
                write_byte(s, val, oe);
                check(i == 0 ? "R3 R1 default-width write" : (w8 ? "R1 write" : "R4 nibble write"),
                      {7'd0, last_cmd}, {7'd0, s, val});
                check("R1 one handoff per byte", 16'(cmd_cnt - base), 16'd1);
                check("R7 no drive on write", {8'd0, oe}, 16'h0000);
            end else begin
                if (!s) core_addr = val[6:0];
                read_byte(s, rd, oe);
                check(s ? "R6 data read" : "R2 status read", {8'd0, rd}, {8'd0, exp});
                check(w8 ? "R7 full drive" : "R7 R4 upper lanes only", {8'd0, oe},
                      w8 ? 16'h00FF : 16'h00F0);
            end
        end

        // R5: first nibble alone produces no handoff
        base = cmd_cnt;
        strobe(1'b0, 1'b0, 8'h4F, rd, oe);
        repeat (10) @(negedge clk);
        check("R5 no handoff after first nibble", {15'd0, cmd_valid}, 16'd0);
        check("R5 count after first nibble", 16'(cmd_cnt - base), 16'd0);
        strobe(1'b0, 1'b0, 8'h80, rd, oe);
        check("R5 byte after second nibble", {7'd0, last_cmd}, {7'd0, 9'h048});

        // R8: width toggle discards a half byte
        strobe(1'b0, 1'b0, 8'hF0, rd, oe);
        width_load(1'b1);
        width_load(1'b0);
        base = cmd_cnt;
        write_byte(1'b0, 8'h27, oe);
        check("R8 phase rewound", {7'd0, last_cmd}, {7'd0, 9'h027});
        check("R8 single handoff", 16'(cmd_cnt - base), 16'd1);

        // R2: core busy shows on bit 7
        width_load(1'b1);
        core_busy = 1'b1; core_addr = 7'h05;
        read_byte(1'b0, rd, oe);
        check("R2 busy bit", {8'd0, rd}, 16'h0085);
        core_busy = 1'b0;

        // R9: pending handoff holds and blocks a later write
        cmd_ready = 1'b0;
        base = cmd_cnt;
        write_byte(1'b0, 8'h01, oe);
        core_addr = 7'h10;
        read_byte(1'b0, rd, oe);
        check("R2 pending handoff reads busy", {8'd0, rd}, 16'h0090);
        write_byte(1'b0, 8'h02, oe);
        check("R9 command held", {7'd0, cmd_valid, cmd_is_data, cmd_byte}, {7'd0, 1'b1, 1'b0, 8'h01});
        @(negedge clk);
        cmd_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 held byte delivered", {7'd0, last_cmd}, {7'd0, 9'h001});
        check("R9 later write dropped", 16'(cmd_cnt - base), 16'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule